// File: doc/BRIEF.md
# Configuration Access Retry Engine

This block sits between a root port's configuration access port and the link-side request/completion path. It takes one configuration read or write at a time, with the target bus, device, function, register offset, access size, write data and a write flag. It forwards the request downstream and waits for a completion status. It then finishes the access, or it replays the request after a fixed pause when the endpoint reports that it is not yet ready.

Pauses between replays are a parameterised number of clock cycles, one microsecond's worth. The number of replays is also a parameter. When the replays run out, the access ends with a timeout result. There is one exception to replaying. If software visibility of retry status is turned on, a read of the dword that holds the vendor identifier ends at once with a fixed marker value. Accesses to bus 0 target the root complex itself, so they are never replayed. Read data comes back already shifted down to the requested byte lane and masked to the requested width.

Top module: `cfg_retry_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `dn_valid` is 0 and `rsp_valid` is 0.
- R2: Only one access is in flight. `req_ready` falls on the cycle after acceptance and stays low until after the response cycle. While `dn_valid` is high, the forwarded request fields stay stable until `dn_ack`.
- R3: A completion status of 0 (success) ends the access. `rsp_valid` is high in the cycle after the `dn_ack` cycle, with `rsp_err`=0 and `rsp_timeout`=0.
- R4: A completion status of 2 (retry) with visibility disabled causes the same request to be sent again. This applies to reads and writes at any offset.
- R5: After a retry completion that leads to a replay, `dn_valid` stays low for exactly CLKS_PER_US cycles and then rises again.
- R6: Visibility applies when `crs_vis_en`=1, the access is a read, and offset bits [11:2] are zero. In that case a retry completion ends the access with no replay. The dword value is 0xFFFF0001, which then goes through the R9 extraction, and `rsp_err`=0.
- R7: With `crs_vis_en`=1, writes and reads of any other dword are still replayed on a retry completion.
- R8: A request is sent at most MAX_RETRIES+1 times. If the last of these gets a retry completion, the response has `rsp_timeout`=1. For a read it carries `rsp_data`=0xFFFFFFFF for any size and `rsp_err`=0. For a write it carries `rsp_err`=1.
- R9: Size code 0 returns dword >> (8 × offset[1:0]) masked to 8 bits. Code 1 returns the same shift masked to 16 bits. Codes 2 and 3 return the whole dword with no shift.
- R10: A completion status other than 0 or 2 ends the access with no replay, `rsp_err`=1 and `rsp_data`=0xFFFFFFFF.
- R11: Accesses to bus 0 are sent once and never replayed. They return the R9-extracted completion data, with `rsp_err`=1 if the status is not 0.
- R12: `rsp_valid` is a single-cycle pulse, given once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_vis_en | input | 1 | Enable software visibility of retry status for vendor-ID reads |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | 5 | Target device |
| req_fn | input | 3 | Target function |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 2 | Size code: 0 byte, 1 half-word, 2/3 dword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Request presented to link side |
| dn_ack | input | 1 | Completion returned; status and data valid this cycle |
| dn_status | input | 3 | Completion status (0 success, 2 retry) |
| dn_rdata | input | 32 | Completion dword |
| dn_bus | output | BUS_W | Forwarded bus |
| dn_dev | output | 5 | Forwarded device |
| dn_fn | output | 3 | Forwarded function |
| dn_off | output | OFF_W | Forwarded offset |
| dn_size | output | 2 | Forwarded size code |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Extracted read data |
| rsp_err | output | 1 | Access ended in error |
| rsp_timeout | output | 1 | Replay budget exhausted |

## Verification
The request is accepted at a rising edge. `dn_valid` is high from the next cycle onward. The response appears exactly one cycle after the cycle in which `dn_ack` is sampled. After a replaying retry completion, the next `dn_valid` comes after exactly CLKS_PER_US low cycles. The bench drives inputs on falling edges and samples on the same falling edges. It counts low cycles of `dn_valid` since the last acknowledge, and it requires that count to be zero when `rsp_valid` is seen and equal to CLKS_PER_US when a replay appears. This timing is checked on every access, alongside the number of issues and the final data, error and timeout flags.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
   localparam logic [2:0] ST_SUCCESS = 3'd0;
   localparam logic [2:0] ST_RETRY   = 3'd2;
   localparam logic [31:0] VIS_MARKER = 32'hFFFF_0001;
   localparam logic [31:0] ALL_ONES   = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ISSUE,
      S_PAUSE,
      S_RESP
   } rty_state_e;
endpackage

// File: rtl/cfg_retry_pacer.sv
module cfg_retry_pacer #(
   parameter int CLKS_PER_US = 125,
   parameter int MAX_RETRIES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic replay,
   output logic pause_done,
   output logic exhausted
);
   localparam int CNT_W = (MAX_RETRIES > 0) ? $clog2(MAX_RETRIES + 1) : 1;
   localparam int GAP_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

   logic [CNT_W-1:0] replays_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      replays_q <= '0;
      else if (start)  replays_q <= '0;
      else if (replay) replays_q <= replays_q + 1'b1;
   end

   assign exhausted = (replays_q == CNT_W'(MAX_RETRIES));

   generate
      if (CLKS_PER_US == 1) begin : g_single
         assign pause_done = 1'b1;
      end else begin : g_count
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              gap_q <= '0;
            else if (replay)         gap_q <= GAP_W'(CLKS_PER_US - 1);
            else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
         end
         assign pause_done = (gap_q == '0);
      end
   endgenerate
endmodule

// File: rtl/cfg_lane_extract.sv
module cfg_lane_extract (
   input  logic [31:0] dword,
   input  logic [1:0]  lane,
   input  logic [1:0]  size,
   output logic [31:0] value
);
   logic [31:0] shifted;
   logic [31:0] mask;

   assign shifted = size[1] ? dword : (dword >> {lane, 3'b000});

   generate
      for (genvar b = 0; b < 4; b++) begin : g_lane
         localparam int NEED = (b == 0) ? 0 : ((b == 1) ? 1 : 2);
         assign mask[b*8 +: 8] = (size >= 2'(NEED)) ? 8'hFF : 8'h00;
      end
   endgenerate

   assign value = shifted & mask;
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
   import cfg_retry_pkg::*;
#(
   parameter int CLKS_PER_US = 125,
   parameter int MAX_RETRIES = 500000,
   parameter int BUS_W       = 8,
   parameter int OFF_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crs_vis_en,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [BUS_W-1:0] req_bus,
   input  logic [4:0]       req_dev,
   input  logic [2:0]       req_fn,
   input  logic [OFF_W-1:0] req_off,
   input  logic [1:0]       req_size,
   input  logic             req_write,
   input  logic [31:0]      req_wdata,
   output logic             dn_valid,
   input  logic             dn_ack,
   input  logic [2:0]       dn_status,
   input  logic [31:0]      dn_rdata,
   output logic [BUS_W-1:0] dn_bus,
   output logic [4:0]       dn_dev,
   output logic [2:0]       dn_fn,
   output logic [OFF_W-1:0] dn_off,
   output logic [1:0]       dn_size,
   output logic             dn_write,
   output logic [31:0]      dn_wdata,
   output logic             rsp_valid,
   output logic [31:0]      rsp_data,
   output logic             rsp_err,
   output logic             rsp_timeout
);
   if (CLKS_PER_US < 1) begin : g_bad_pace
      $error("CLKS_PER_US must be at least 1");
   end
   if (MAX_RETRIES < 0) begin : g_bad_retries
      $error("MAX_RETRIES must not be negative");
   end
   if (OFF_W < 3) begin : g_bad_off
      $error("OFF_W must be at least 3");
   end

   rty_state_e state_q, state_d;
   logic       accept, finish, replay;
   logic       pause_done, exhausted;
   logic       at_root, got_retry, vis_hit;
   logic [31:0] ext_in, ext_out, data_d;
   logic        err_d, to_d, raw_ones;

   assign req_ready = (state_q == S_IDLE);
   assign accept    = req_valid && req_ready;
   assign dn_valid  = (state_q == S_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_bus   <= '0;
         dn_dev   <= '0;
         dn_fn    <= '0;
         dn_off   <= '0;
         dn_size  <= '0;
         dn_write <= 1'b0;
         dn_wdata <= '0;
      end else if (accept) begin
         dn_bus   <= req_bus;
         dn_dev   <= req_dev;
         dn_fn    <= req_fn;
         dn_off   <= req_off;
         dn_size  <= req_size;
         dn_write <= req_write;
         dn_wdata <= req_wdata;
      end
   end

   assign at_root   = (dn_bus == '0);
   assign got_retry = (dn_status == ST_RETRY);
   assign vis_hit   = crs_vis_en && !dn_write && (dn_off[OFF_W-1:2] == '0);

   always_comb begin
      finish   = 1'b0;
      replay   = 1'b0;
      err_d    = 1'b0;
      to_d     = 1'b0;
      raw_ones = 1'b0;
      ext_in   = dn_rdata;
      if (dn_valid && dn_ack) begin
         if (at_root) begin
            finish = 1'b1;
            err_d  = (dn_status != ST_SUCCESS);
         end else if (got_retry && vis_hit) begin
            finish = 1'b1;
            ext_in = VIS_MARKER;
         end else if (got_retry && exhausted) begin
            finish   = 1'b1;
            to_d     = 1'b1;
            err_d    = dn_write;
            raw_ones = 1'b1;
         end else if (got_retry) begin
            replay = 1'b1;
         end else if (dn_status == ST_SUCCESS) begin
            finish = 1'b1;
         end else begin
            finish   = 1'b1;
            err_d    = 1'b1;
            raw_ones = 1'b1;
         end
      end
   end

   cfg_lane_extract u_extract (
      .dword (ext_in),
      .lane  (dn_off[1:0]),
      .size  (dn_size),
      .value (ext_out)
   );

   assign data_d = raw_ones ? ALL_ONES : ext_out;

   cfg_retry_pacer #(
      .CLKS_PER_US (CLKS_PER_US),
      .MAX_RETRIES (MAX_RETRIES)
   ) u_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .replay     (replay),
      .pause_done (pause_done),
      .exhausted  (exhausted)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:  if (accept) state_d = S_ISSUE;
         S_ISSUE: if (finish) state_d = S_RESP;
                  else if (replay) state_d = S_PAUSE;
         S_PAUSE: if (pause_done) state_d = S_ISSUE;
         S_RESP:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         rsp_data    <= '0;
         rsp_err     <= 1'b0;
         rsp_timeout <= 1'b0;
      end else begin
         state_q <= state_d;
         if (finish) begin
            rsp_data    <= data_d;
            rsp_err     <= err_d;
            rsp_timeout <= to_d;
         end
      end
   end

   assign rsp_valid = (state_q == S_RESP);
endmodule

// File: rtl/cfg_retry_chk.sv
module cfg_retry_chk #(
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             dn_valid,
   input logic             dn_ack,
   input logic [OFF_W-1:0] dn_off,
   input logic             rsp_valid,
   input logic             rsp_err,
   input logic             rsp_timeout,
   input logic [31:0]      rsp_data
);
   AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R2
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid || rsp_valid) |-> !req_ready); // R2
   AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ack |=> dn_valid && $stable(dn_off)); // R2
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_ack |=> !dn_valid); // R5
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R12
   AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_timeout && !rsp_err |-> rsp_data == 32'hFFFF_FFFF); // R8
endmodule

bind cfg_retry_ctrl cfg_retry_chk #(.OFF_W(OFF_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .dn_valid    (dn_valid),
   .dn_ack      (dn_ack),
   .dn_off      (dn_off),
   .rsp_valid   (rsp_valid),
   .rsp_err     (rsp_err),
   .rsp_timeout (rsp_timeout),
   .rsp_data    (rsp_data)
);

// File: tb/cfg_retry_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_retry_ctrl_bench;
   localparam int CLKS = 4;
   localparam int MAXR = 5;
   localparam int NEVER = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic crs_vis_en = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_fn = '0;
   logic [11:0] req_off = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        dn_valid;
   logic        dn_ack = 1'b0;
   logic [2:0]  dn_status = '0;
   logic [31:0] dn_rdata = '0;
   logic [7:0]  dn_bus;
   logic [4:0]  dn_dev;
   logic [2:0]  dn_fn;
   logic [11:0] dn_off;
   logic [1:0]  dn_size;
   logic        dn_write;
   logic [31:0] dn_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_err;
   logic        rsp_timeout;

   int n_checks = 0;
   int n_fail = 0;

   int          g_issues;
   logic [31:0] g_data;
   logic        g_err;
   logic        g_to;

   always #4 clk = ~clk;

   cfg_retry_ctrl #(.CLKS_PER_US(CLKS), .MAX_RETRIES(MAXR)) u_cfg_retry_ctrl (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one access; the first n_retry acks carry status 2, later ones fin_st.
   task automatic access(input logic [7:0] bus, input logic [11:0] off, input logic [1:0] size,
                         input logic wr, input int n_retry, input logic [2:0] fin_st,
                         input logic [31:0] fin_data, input string req);
      int low;
      bit done;
      @(negedge clk);
      check(req_ready === 1'b1, {req, " ready before request"}, 32'(req_ready), 32'd1);
      req_bus = bus; req_dev = 5'd3; req_fn = 3'd1; req_off = off;
      req_size = size; req_write = wr; req_wdata = 32'h5A5A_0000 | 32'(off);
      req_valid = 1'b1;
      g_issues = 0;
      low = 0;
      done = 0;
      for (int it = 0; it < 400 && !done; it++) begin
         @(negedge clk);
         req_valid = 1'b0;
         dn_ack = 1'b0;
         if (rsp_valid) begin
            check(low == 0, {req, " response one cycle after ack (R3)"}, 32'(low), 32'd0);
            g_data = rsp_data; g_err = rsp_err; g_to = rsp_timeout;
            done = 1;
         end else if (dn_valid) begin
            if (g_issues > 0)
               check(low == CLKS, {req, " replay pause (R5)"}, 32'(low), 32'(CLKS));
            if (dn_off !== off || dn_bus !== bus || dn_write !== wr)
               check(1'b0, {req, " forwarded fields (R2)"}, 32'(dn_off), 32'(off));
            g_issues++;
            dn_ack = 1'b1;
            dn_status = (g_issues <= n_retry) ? 3'd2 : fin_st;
            dn_rdata = fin_data;
            low = 0;
         end else begin
            low++;
         end
      end
      check(done, {req, " response seen"}, 32'(done), 32'd1);
      @(negedge clk);
      check(rsp_valid === 1'b0, {req, " single response pulse (R12)"}, 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_reset;
      check(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
      check(dn_valid === 1'b0, "R1 dn_valid", 32'(dn_valid), 32'd0);
      check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_plain_read;
      crs_vis_en = 1'b0;
      access(8'd1, 12'h010, 2'd2, 1'b0, 0, 3'd0, 32'hDEAD_BEEF, "R3");
      check(g_issues == 1, "R3 issues", 32'(g_issues), 32'd1);
      check(g_data == 32'hDEAD_BEEF && !g_err && !g_to, "R3 data", g_data, 32'hDEAD_BEEF);
   endtask

   task automatic t_retry_read;
      crs_vis_en = 1'b0;
      access(8'd2, 12'h040, 2'd2, 1'b0, 2, 3'd0, 32'h1234_5678, "R4");
      check(g_issues == 3, "R4 read replays", 32'(g_issues), 32'd3);
      check(g_data == 32'h1234_5678 && !g_err, "R4 read data", g_data, 32'h1234_5678);
      access(8'd2, 12'h000, 2'd2, 1'b0, 2, 3'd0, 32'h0ABC_1AF4, "R4 vid");
      check(g_issues == 3, "R4 vendor read replays when visibility off", 32'(g_issues), 32'd3);
   endtask

   task automatic t_vis;
      crs_vis_en = 1'b1;
      access(8'd4, 12'h000, 2'd2, 1'b0, NEVER, 3'd0, 32'h0, "R6 dword");
      check(g_issues == 1, "R6 no replay", 32'(g_issues), 32'd1);
      check(g_data == 32'hFFFF_0001 && !g_err && !g_to, "R6 marker", g_data, 32'hFFFF_0001);
      access(8'd4, 12'h000, 2'd1, 1'b0, NEVER, 3'd0, 32'h0, "R6 low half");
      check(g_data == 32'h0000_0001, "R6 low half value", g_data, 32'h1);
      access(8'd4, 12'h002, 2'd1, 1'b0, NEVER, 3'd0, 32'h0, "R6 high half");
      check(g_data == 32'h0000_FFFF, "R6 high half value", g_data, 32'hFFFF);
   endtask

   task automatic t_vis_others;
      crs_vis_en = 1'b1;
      access(8'd5, 12'h008, 2'd2, 1'b0, 1, 3'd0, 32'hCAFE_0008, "R7 read");
      check(g_issues == 2 && g_data == 32'hCAFE_0008, "R7 other read replayed", 32'(g_issues), 32'd2);
      access(8'd5, 12'h000, 2'd2, 1'b1, 1, 3'd0, 32'h0, "R7 write");
      check(g_issues == 2 && !g_err, "R7 write replayed", 32'(g_issues), 32'd2);
      crs_vis_en = 1'b0;
   endtask

   task automatic t_timeout;
      access(8'd6, 12'h020, 2'd0, 1'b0, NEVER, 3'd0, 32'h0, "R8 read");
      check(g_issues == MAXR + 1, "R8 read issue count", 32'(g_issues), 32'(MAXR + 1));
      check(g_data == 32'hFFFF_FFFF && g_to && !g_err, "R8 read result", g_data, 32'hFFFF_FFFF);
      access(8'd6, 12'h020, 2'd2, 1'b1, NEVER, 3'd0, 32'h0, "R8 write");
      check(g_issues == MAXR + 1 && g_to && g_err, "R8 write flags", {30'd0, g_to, g_err}, 32'd3);
      access(8'd6, 12'h020, 2'd2, 1'b0, MAXR, 3'd0, 32'h7777_0000, "R8 last try");
      check(g_issues == MAXR + 1 && !g_to && g_data == 32'h7777_0000, "R8 success on last try",
            g_data, 32'h7777_0000);
   endtask

   task automatic t_lanes;
      access(8'd7, 12'h013, 2'd0, 1'b0, 0, 3'd0, 32'hA1B2_C3D4, "R9 byte3");
      check(g_data == 32'h0000_00A1, "R9 byte lane 3", g_data, 32'hA1);
      access(8'd7, 12'h011, 2'd0, 1'b0, 0, 3'd0, 32'hA1B2_C3D4, "R9 byte1");
      check(g_data == 32'h0000_00C3, "R9 byte lane 1", g_data, 32'hC3);
      access(8'd7, 12'h012, 2'd1, 1'b0, 0, 3'd0, 32'hA1B2_C3D4, "R9 half");
      check(g_data == 32'h0000_A1B2, "R9 upper half", g_data, 32'hA1B2);
      access(8'd7, 12'h013, 2'd3, 1'b0, 0, 3'd0, 32'hA1B2_C3D4, "R9 dword");
      check(g_data == 32'hA1B2_C3D4, "R9 dword no shift", g_data, 32'hA1B2_C3D4);
   endtask

   task automatic t_bad_status;
      access(8'd8, 12'h030, 2'd2, 1'b0, 0, 3'd1, 32'h1111_1111, "R10");
      check(g_issues == 1 && g_err && !g_to, "R10 error no replay", 32'(g_issues), 32'd1);
      check(g_data == 32'hFFFF_FFFF, "R10 data", g_data, 32'hFFFF_FFFF);
   endtask

   task automatic t_root;
      access(8'd0, 12'h001, 2'd0, 1'b0, 0, 3'd0, 32'h0000_9900, "R11 ok");
      check(g_issues == 1 && !g_err && g_data == 32'h99, "R11 root read", g_data, 32'h99);
      access(8'd0, 12'h040, 2'd2, 1'b0, NEVER, 3'd0, 32'h4242_4242, "R11 retry");
      check(g_issues == 1 && g_err && !g_to, "R11 root not replayed", 32'(g_issues), 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_read();
      t_retry_read();
      t_vis();
      t_vis_others();
      t_timeout();
      t_lanes();
      t_bad_status();
      t_root();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule